// File: doc/BRIEF.md
# Local interrupt count-down timer

This block is a per-processor down-counter that software drives through a four-word register port. A timer entry holds the interrupt vector, a mask flag and a mode flag; a divide register picks how many bus clocks make one counter step; writing the initial count loads the counter and starts it. When the count runs out, the block raises a one-clock interrupt request tagged with the programmed vector. In one-shot mode it then stops at zero. In periodic mode it reloads and keeps going.

Masking the entry blocks the request while the counter keeps running. Software can therefore read the current count to calibrate the timer against another time base without taking interrupts. Priority handling and delivery to the core sit outside this block.

Top module: `lit_timer`

## Requirements
- R1: After a synchronous reset the entry reads 0x0001_0000: vector 0, mask bit 16 set, mode bit 17 clear (one-shot). The divide register, the initial count and the current count all read zero, and irq_valid is low.
- R2: Word 0 (the entry) stores the vector in bits 7:0, the mask in bit 16 and the periodic mode in bit 17. It reads them back as written, with every other bit zero. Writing the mask leaves the stored vector unchanged.
- R3: A write to word 2 loads the written value into the counter in the next cycle and starts counting. A new write while counting restarts from the new value. Word 2 always reads zero.
- R4: Word 3 returns the current count, which drops by one every D clocks. D is the divide ratio, and the phase restarts at each word 2 write.
- R5: Word 1 keeps only bits 3, 1 and 0 and reads zero elsewhere. The code c = {bit3, bit1, bit0} selects the ratio: c = 3'b011 gives 16, c = 3'b111 gives 1, and any other c gives 2^(c+1).
- R6: In one-shot mode, a count of N written with ratio D reaches zero N*D clocks after the write. It then raises exactly one request and stays at zero.
- R7: In periodic mode the counter reloads the last written initial count instead of reaching zero. It raises a request every N*D clocks.
- R8: While the mask is set the counter still runs and reloads, but irq_valid stays low.
- R9: A request is irq_valid high for one clock in the cycle after the expiring step, with irq_vector equal to the vector programmed at that step.
- R10: Writing an initial count of zero stops the counter at zero, and no request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word select: 0 entry, 1 divide, 2 initial count, 3 current count |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_valid | output | 1 | One-clock interrupt request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
The assertions check the following on every cycle:
- a request appears only after an expiring step;
- a masked expiry stays silent;
- the vector follows the entry;
- one-shot expiry leaves the counter stopped at zero;
- periodic expiry reloads the initial count;
- each prescaled step lowers the count by exactly one;
- a zero load stops the counter.

Only the bench scenarios can show the end-to-end timing. That covers the exact distance of N*D clocks from a write to the request for each divide code, the number of requests over a long window, restarts in mid-count, and the read-back encodings of all four words.

// File: rtl/lit_pkg.sv
package lit_pkg;
  typedef enum logic [1:0] {
    A_ENTRY = 2'd0,
    A_DIV   = 2'd1,
    A_INIT  = 2'd2,
    A_CUR   = 2'd3
  } lit_addr_e;

  localparam int MASK_BIT = 16;
  localparam int MODE_BIT = 17;

  // Gather the scattered divide bits {3,1,0} into a 3-bit code.
  function automatic logic [2:0] div_code(input logic [31:0] w);
    return {w[3], w[1], w[0]};
  endfunction

  // Log2 of the divide ratio: code+1 modulo 8 (3'b111 -> 0, i.e. /1).
  function automatic logic [2:0] div_shift(input logic [2:0] c);
    return c + 3'd1;
  endfunction
endpackage

// File: rtl/lit_regs.sv
module lit_regs
  import lit_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cur,
  output logic [DATA_W-1:0] rdata,
  output logic [VEC_W-1:0]  vector,
  output logic              mask,
  output logic              periodic,
  output logic [2:0]        dcode,
  output logic [CNT_W-1:0]  init_val,
  output logic              init_wr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vector   <= '0;
      mask     <= 1'b1;
      periodic <= 1'b0;
      dcode    <= 3'd0;
      init_val <= '0;
    end else if (we) begin
      case (addr)
        A_ENTRY: begin
          vector   <= wdata[VEC_W-1:0];
          mask     <= wdata[MASK_BIT];
          periodic <= wdata[MODE_BIT];
        end
        A_DIV:   dcode    <= div_code(wdata);
        A_INIT:  init_val <= wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  assign init_wr = we && (addr == A_INIT);

  always_comb begin
    rdata = '0;
    case (addr)
      A_ENTRY: begin
        rdata[VEC_W-1:0] = vector;
        rdata[MASK_BIT]  = mask;
        rdata[MODE_BIT]  = periodic;
      end
      A_DIV: begin
        rdata[3]   = dcode[2];
        rdata[1:0] = dcode[1:0];
      end
      A_CUR:   rdata[CNT_W-1:0] = cur;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/lit_prescaler.sv
module lit_prescaler #(
  parameter int MAX_SHIFT = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic [2:0] shift,
  output logic       tick
);
  localparam int PRE_W = MAX_SHIFT;

  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] sel_mask;

  // (1 << shift) - 1 in PRE_W bits; shift = MAX_SHIFT wraps to all ones.
  assign sel_mask = (PRE_W'(1) << shift) - PRE_W'(1);
  assign tick     = ((pre & sel_mask) == sel_mask);

  always_ff @(posedge clk) begin
    if (rst || restart) pre <= '0;
    else                pre <= pre + PRE_W'(1);
  end
endmodule

// File: rtl/lit_counter.sv
module lit_counter #(
  parameter int VEC_W = 8,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             tick,
  input  logic             periodic,
  input  logic             mask,
  input  logic [VEC_W-1:0] vector,
  output logic [CNT_W-1:0] cur,
  output logic             running,
  output logic             expire,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vector
);
  assign expire = running && tick && !load && (cur == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cur        <= '0;
      running    <= 1'b0;
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_valid <= expire && !mask;
      if (expire) irq_vector <= vector;
      if (load) begin
        cur     <= load_val;
        running <= (load_val != '0);
      end else if (expire) begin
        cur     <= periodic ? reload_val : '0;
        running <= periodic;
      end else if (running && tick) begin
        cur <= cur - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/lit_timer.sv
module lit_timer
  import lit_pkg::*;
#(
  parameter int VEC_W     = 8,
  parameter int CNT_W     = 32,
  parameter int DATA_W    = 32,
  parameter int MAX_SHIFT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vector
);
  logic [VEC_W-1:0] vector_w;
  logic             mask_w;
  logic             periodic_w;
  logic [2:0]       dcode_w;
  logic [CNT_W-1:0] init_w;
  logic             init_wr_w;
  logic             tick_w;
  logic [CNT_W-1:0] cur_w;
  logic             running_w;
  logic             expire_w;

  lit_regs #(.VEC_W(VEC_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .cur(cur_w), .rdata(reg_rdata), .vector(vector_w), .mask(mask_w),
    .periodic(periodic_w), .dcode(dcode_w), .init_val(init_w),
    .init_wr(init_wr_w)
  );

  lit_prescaler #(.MAX_SHIFT(MAX_SHIFT)) u_pre (
    .clk(clk), .rst(rst), .restart(init_wr_w),
    .shift(div_shift(dcode_w)), .tick(tick_w)
  );

  lit_counter #(.VEC_W(VEC_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(init_wr_w), .load_val(reg_wdata[CNT_W-1:0]),
    .reload_val(init_w), .tick(tick_w), .periodic(periodic_w),
    .mask(mask_w), .vector(vector_w), .cur(cur_w), .running(running_w),
    .expire(expire_w), .irq_valid(irq_valid), .irq_vector(irq_vector)
  );
endmodule

// File: rtl/lit_timer_checker.sv
module lit_timer_checker #(
  parameter int VEC_W  = 8,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              irq_valid,
  input logic [VEC_W-1:0]  irq_vector,
  input logic              expire_w,
  input logic              mask_w,
  input logic              periodic_w,
  input logic [VEC_W-1:0]  vector_w,
  input logic [CNT_W-1:0]  cur_w,
  input logic [CNT_W-1:0]  init_w,
  input logic              running_w,
  input logic              tick_w,
  input logic              init_wr_w
);
  assert_no_spurious_irq_R9: assert property (@(posedge clk) disable iff (rst)
    !expire_w |=> !irq_valid);

  assert_masked_silent_R8: assert property (@(posedge clk) disable iff (rst)
    (expire_w && mask_w) |=> !irq_valid);

  assert_irq_vector_R9: assert property (@(posedge clk) disable iff (rst)
    (expire_w && !mask_w) |=> (irq_valid && irq_vector == $past(vector_w)));

  assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (rst)
    (expire_w && !periodic_w) |=> (cur_w == '0 && !running_w));

  assert_periodic_reload_R7: assert property (@(posedge clk) disable iff (rst)
    (expire_w && periodic_w) |=> (cur_w == $past(init_w) && running_w));

  assert_step_R4: assert property (@(posedge clk) disable iff (rst)
    (running_w && tick_w && !init_wr_w && cur_w > CNT_W'(1))
      |=> cur_w == $past(cur_w) - CNT_W'(1));

  assert_zero_load_R10: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 2'd2 && reg_wdata[CNT_W-1:0] == '0)
      |=> (cur_w == '0 && !running_w && !irq_valid));

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (!running_w && !init_wr_w) |=> $stable(cur_w));
endmodule

bind lit_timer lit_timer_checker #(.VEC_W(VEC_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq_valid(irq_valid), .irq_vector(irq_vector),
  .expire_w(expire_w), .mask_w(mask_w), .periodic_w(periodic_w),
  .vector_w(vector_w), .cur_w(cur_w), .init_w(init_w),
  .running_w(running_w), .tick_w(tick_w), .init_wr_w(init_wr_w)
);

// File: tb/lit_timer_test.sv
module lit_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd3;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  lit_timer uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  always #2.5 clk = ~clk;

  int    n_vec  = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    started = 0;
  bit    done = 0;

  // Behavioural reference model
  logic [31:0] m_cur, m_init;
  bit          m_run, m_mask, m_per, m_irq;
  logic [7:0]  m_vec, m_ivec;
  logic [2:0]  m_dc;
  int          m_clocks;

  function automatic int ratio(input logic [2:0] c);
    if (c == 3'b011) return 16;
    if (c == 3'b111) return 1;
    return 2 ** (int'(c) + 1);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cur = 0; m_init = 0; m_run = 0; m_mask = 1; m_per = 0;
      m_irq = 0; m_vec = 0; m_ivec = 0; m_dc = 0; m_clocks = 0;
    end else begin
      bit tick;
      bit fire;
      tick = (m_clocks % ratio(m_dc)) == ratio(m_dc) - 1;
      fire = 0;
      if (reg_we && reg_addr == 2'd2) begin
        m_cur = reg_wdata; m_init = reg_wdata; m_run = (reg_wdata != 0);
        m_clocks = 0;
      end else begin
        m_clocks = m_clocks + 1;
        if (m_run && tick) begin
          if (m_cur == 1) begin
            fire = 1;
            m_ivec = m_vec;
            if (m_per) m_cur = m_init;
            else begin m_cur = 0; m_run = 0; end
          end else m_cur = m_cur - 1;
        end
      end
      m_irq = fire && !m_mask;
      if (reg_we && reg_addr == 2'd0) begin
        m_vec = reg_wdata[7:0]; m_mask = reg_wdata[16]; m_per = reg_wdata[17];
      end
      if (reg_we && reg_addr == 2'd1) m_dc = {reg_wdata[3], reg_wdata[1], reg_wdata[0]};
    end
    started = 1;
  end

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return {14'd0, m_per, m_mask, 8'd0, m_vec};
      2'd1: return {28'd0, m_dc[2], 1'b0, m_dc[1:0]};
      2'd2: return 32'd0;
      default: return m_cur;
    endcase
  endfunction

  always @(negedge clk) begin
    if (started && !done) begin
      n_vec++;
      if (irq_valid !== m_irq || (m_irq && irq_vector !== m_ivec) ||
          reg_rdata !== exp_rd(reg_addr)) begin
        n_fail++;
        $display("FAIL %s: irq=%b vec=%h rdata=%h, expected irq=%b vec=%h rdata=%h",
                 cur_req, irq_valid, irq_vector, reg_rdata, m_irq, m_ivec,
                 exp_rd(reg_addr));
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0; reg_addr = 2'd3;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    #1 reg_addr = 2'd3;
  endtask

  task automatic run(input int k, output int pulses);
    pulses = 0;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      if (irq_valid) pulses++;
    end
  endtask

  initial begin
    logic [31:0] d;
    int p;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    cur_req = "R1";
    rd(2'd0, d); check(d == 32'h0001_0000, "R1", d, 32'h0001_0000);
    rd(2'd1, d); check(d == 0, "R1", d, 0);
    rd(2'd3, d); check(d == 0, "R1", d, 0);
    check(irq_valid == 0, "R1", irq_valid, 0);

    cur_req = "R2";
    wr(2'd0, 32'hFFFF_FF31);
    rd(2'd0, d); check(d == 32'h0003_0031, "R2", d, 32'h0003_0031);
    wr(2'd0, 32'h0001_0031);
    rd(2'd0, d); check(d == 32'h0001_0031, "R2", d, 32'h0001_0031);

    cur_req = "R5";
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); check(d == 32'hB, "R5", d, 32'hB);
    wr(2'd1, 32'h3);
    rd(2'd1, d); check(d == 32'h3, "R5", d, 32'h3);

    cur_req = "R6";
    wr(2'd0, 32'h0000_0031);
    wr(2'd2, 5);
    run(120, p); check(p == 1, "R6", p, 1);
    rd(2'd3, d); check(d == 0, "R6", d, 0);

    cur_req = "R7";
    wr(2'd1, 32'hB);
    wr(2'd0, 32'h0002_00A5);
    wr(2'd2, 4);
    run(21, p); check(p == 5, "R7", p, 5);

    cur_req = "R9";
    wr(2'd0, 32'h0002_005C);
    wr(2'd2, 3);
    run(10, p); check(p == 3, "R9", p, 3);

    cur_req = "R8";
    wr(2'd0, 32'h0003_005C);
    wr(2'd2, 3);
    run(20, p); check(p == 0, "R8", p, 0);
    rd(2'd3, d); check(d >= 1 && d <= 3, "R8", d, 3);

    cur_req = "R4";
    wr(2'd1, 32'h0);
    wr(2'd0, 32'h0000_0011);
    wr(2'd2, 3);
    run(7, p); check(p == 1, "R4", p, 1);
    wr(2'd1, 32'h2);
    wr(2'd2, 2);
    run(17, p); check(p == 1, "R4", p, 1);

    cur_req = "R3";
    wr(2'd1, 32'hB);
    wr(2'd2, 100);
    run(10, p);
    wr(2'd2, 50);
    rd(2'd2, d); check(d == 0, "R3", d, 0);
    rd(2'd3, d); check(d < 50 && d > 40, "R3", d, 48);
    run(60, p); check(p == 1, "R3", p, 1);

    cur_req = "R10";
    wr(2'd0, 32'h0002_0011);
    wr(2'd2, 8);
    run(4, p);
    wr(2'd2, 0);
    run(40, p); check(p == 0, "R10", p, 0);
    rd(2'd3, d); check(d == 0, "R10", d, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule